// File: doc/BRIEF.md
# Memory-Controller Performance Event Counter Unit

This unit watches a memory controller and counts what it does. It holds four counters. Counter 0 counts clock cycles and nothing else. Counters 1 to 3 each pick one of 64 single-cycle event pulse inputs through an 8-bit event code. Example codes are 0x04 (read access), 0x05 (write access), 0x2A (read cycle), 0x2B (write cycle) and 0x31 (precharge). Software drives the unit through a small word-addressed register bus. Each counter has a control word and a read-only count word, and reads return data one cycle after the request.

Counter 0 is more than a cycle counter: it gates the whole unit. The programmable counters advance only while counter 0 is enabled and has not overflowed. When counter 0 wraps, every counter stops and the interrupt line goes high. It stays high until software rewrites counter 0. A programmable counter that wraps sets its own sticky flag and keeps counting, without raising the interrupt.

Top module: `mc_perf_counters`

## Requirements
- R1: After reset, every control word and count word reads 0 and `irq` is low.
- R2: Control word n sits at byte offset 4·n and count word n at 0x20 + 4·n (n = 0..3). A read returns its data on `rdata` in the cycle after `rd_en`. Misaligned, unmapped and idle reads return 0.
- R3: The control word fields are: bit 0 = overflow flag, bit 1 = clear (reads back 0), bit 2 = enable, bits 31:24 = event code. A write with both enable and clear set zeroes the count and starts counting.
- R4: Counter k (k = 1..3) with event code c, where 1 ≤ c ≤ 63, adds one for each cycle in which `event_pulse[c]` is high. One pulse feeds every counter that selects it. Code 0 and codes of 64 or more count nothing.
- R5: Counter 0 adds one on every clock while it is enabled, whatever event code is written. Its event-code field always reads 0.
- R6: While counter 0 is disabled, counters 1 to 3 hold their counts even when their events pulse.
- R7: When counter 0 wraps, it returns to 0 and sets its overflow flag, `irq` rises, and all four counters freeze.
- R8: A programmable counter wraps modulo 2^CNT_W, sets its own overflow flag, keeps counting and leaves `irq` unchanged.
- R9: An overflow flag stays set until a write with clear set or a write of all zeros. An all-zero write stops the counter and keeps its count.
- R10: A write that sets enable on counter 0 while counter 0 is already enabled has no effect. Counter 0 must be written with zero before it can be restarted. Writing zero drops `irq`.
- R11: Writes to count words and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request for `addr` |
| wr_en | input | 1 | Write request of `wdata` to `addr` |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| event_pulse | input | EV_N | Single-cycle event pulses, indexed by event code |
| irq | output | 1 | Cycle counter overflow interrupt |

## Verification
The hardest situations to reach are wraps. With 32-bit counts, a wrap needs billions of cycles, and a programmable counter can never wrap before the cycle counter does, because events occur no more often than cycles. The bench therefore builds the unit with an 8-bit count width. It lets the cycle counter run past 256 clocks to check the freeze and the interrupt. It makes a programmable counter wrap by restarting the cycle counter part way through a 300-pulse event stream.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

  localparam int DATA_W  = 32;
  localparam int SLOT_W  = 3;   // word slots per 32-byte region
  localparam int CODE_W  = 8;

  // control word bit positions (decoded by software)
  localparam int OVF_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int EN_BIT  = 2;
  localparam int SEL_LSB = 24;

  typedef struct packed {
    logic [CODE_W-1:0] sel;
    logic              en;
    logic              ovf;
  } ctl_t;

endpackage

// File: rtl/mcm_event_sel.sv
module mcm_event_sel #(
  parameter int EV_N = 64
) (
  input  logic [EV_N-1:0]            ev,
  input  logic [mcm_pkg::CODE_W-1:0] code,
  output logic                       hit
);
  localparam int IDX_W = $clog2(EV_N);
  localparam logic [mcm_pkg::CODE_W:0] EV_LIMIT = (mcm_pkg::CODE_W+1)'(EV_N);

  logic code_ok;

  always_comb begin
    code_ok = (code != '0) && ({1'b0, code} < EV_LIMIT);
    hit     = code_ok ? ev[code[IDX_W-1:0]] : 1'b0;
  end

endmodule

// File: rtl/mcm_counter.sv
module mcm_counter
  import mcm_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              run,
  input  logic              ev_hit,
  output ctl_t              ctl_q,
  output logic [CNT_W-1:0]  cnt_q
);

  logic             wr_zero;
  logic             wr_eff;
  logic             inc;
  logic             ld;
  ctl_t             ctl_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wr_zero = (wr_data == '0);
    // an enable write to a running cycle counter is dropped
    wr_eff  = wr && !(IS_CYCLE && ctl_q.en && wr_data[EN_BIT]);
    inc     = run && ctl_q.en && ev_hit;
    ld      = wr_eff || inc;
  end

  always_comb begin
    ctl_d = ctl_q;
    cnt_d = cnt_q;
    if (wr_eff) begin
      ctl_d.en  = wr_data[EN_BIT];
      ctl_d.sel = IS_CYCLE ? '0 : wr_data[SEL_LSB +: CODE_W];
      if (wr_zero || wr_data[CLR_BIT]) ctl_d.ovf = 1'b0;
      if (wr_data[CLR_BIT])            cnt_d     = '0;
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (&cnt_q) ctl_d.ovf = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else if (ld) begin
      ctl_q <= ctl_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n) (wr_eff && wr_data[CLR_BIT]) |=> (cnt_q == '0)); // R3
  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n) !wr |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1))); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ctl_q.ovf && !wr) |=> ctl_q.ovf); // R9
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (!wr && inc && (&cnt_q)) |=> (ctl_q.ovf && cnt_q == '0)); // R8
  AST_RESTART_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (IS_CYCLE && wr && ctl_q.en && wr_data[EN_BIT]) |=> ctl_q.en); // R10

endmodule

// File: rtl/mcm_regif.sv
module mcm_regif
  import mcm_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  ctl_t [NUM_CNT-1:0]              ctl,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
  output logic [NUM_CNT-1:0]              ctl_wr,
  output logic [DATA_W-1:0]               rdata
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int REG_W = ADDR_W - SLOT_W - 2;
  localparam logic [REG_W-1:0]  REG_CTL   = REG_W'(0);
  localparam logic [REG_W-1:0]  REG_CNT   = REG_W'(1);
  localparam logic [SLOT_W:0]   NUM_SLOTS = (SLOT_W+1)'(NUM_CNT);

  logic [REG_W-1:0]  region;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              slot_ok;
  logic              ctl_hit;
  logic              cnt_hit;
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    region  = addr[ADDR_W-1 -: REG_W];
    slot    = addr[SLOT_W+1:2];
    idx     = slot[IDX_W-1:0];
    aligned = (addr[1:0] == 2'b00);
    slot_ok = ({1'b0, slot} < NUM_SLOTS);
    ctl_hit = aligned && slot_ok && (region == REG_CTL);
    cnt_hit = aligned && slot_ok && (region == REG_CNT);
  end

  always_comb begin
    for (int k = 0; k < NUM_CNT; k++) begin
      ctl_wr[k] = wr_en && ctl_hit && (idx == IDX_W'(k));
    end
  end

  always_comb begin
    rd_d = '0;
    if (ctl_hit) begin
      rd_d[SEL_LSB +: CODE_W] = ctl[idx].sel;
      rd_d[EN_BIT]            = ctl[idx].en;
      rd_d[OVF_BIT]           = ctl[idx].ovf;
    end else if (cnt_hit) begin
      rd_d = DATA_W'(cnt[idx]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_d : '0;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !ctl_hit && !cnt_hit) |=> (rdata == '0)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> (rdata == '0)); // R2

endmodule

// File: rtl/mc_perf_counters.sv
module mc_perf_counters
  import mcm_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int EV_N    = 64,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [EV_N-1:0]   event_pulse,
  output logic              irq
);

  ctl_t [NUM_CNT-1:0]            ctl;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            ctl_wr;
  logic                          run;

  // global gate: cycle counter enabled and not yet wrapped
  always_comb begin
    run = ctl[0].en && !ctl[0].ovf;
    irq = ctl[0].ovf;
  end

  mcm_regif #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W)
  ) u_regif (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .addr   (addr),
    .ctl    (ctl),
    .cnt    (cnt),
    .ctl_wr (ctl_wr),
    .rdata  (rdata)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    logic hit;

    if (k == 0) begin : g_cycle
      assign hit = 1'b1;
    end else begin : g_event
      mcm_event_sel #(.EV_N(EV_N)) u_sel (
        .ev   (event_pulse),
        .code (ctl[k].sel),
        .hit  (hit)
      );
    end

    mcm_counter #(
      .CNT_W    (CNT_W),
      .IS_CYCLE (k == 0)
    ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ctl_wr[k]),
      .wr_data (wdata),
      .run     (run),
      .ev_hit  (hit),
      .ctl_q   (ctl[k]),
      .cnt_q   (cnt[k])
    );

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!run && !ctl_wr[k]) |=> $stable(cnt[k])); // R6
  end

  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(&cnt[0]) && cnt[0] == '0)); // R7
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ctl_wr)); // R2

endmodule

// File: tb/mc_perf_counters_test.sv
module mc_perf_counters_test;

  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [63:0] ev;
  logic        irq;

  int n_chk;
  int n_fail;

  mc_perf_counters #(.CNT_W(8)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .event_pulse (ev),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: sel1 sel2 sel3 pulse_idx n exp1 exp2 exp3
  localparam logic [63:0] VEC [6] = '{
    {8'h04, 8'h05, 8'h2A, 8'd4,  8'd10, 8'd10, 8'd0, 8'd0 },
    {8'h04, 8'h04, 8'h31, 8'd4,  8'd7,  8'd7,  8'd7, 8'd0 },
    {8'h2B, 8'h2A, 8'h2B, 8'd43, 8'd12, 8'd12, 8'd0, 8'd12},
    {8'h00, 8'h05, 8'h45, 8'd0,  8'd9,  8'd0,  8'd0, 8'd0 },
    {8'h3F, 8'h05, 8'h45, 8'd5,  8'd6,  8'd0,  8'd6, 8'd0 },
    {8'h3F, 8'h01, 8'h3F, 8'd63, 8'd20, 8'd20, 8'd0, 8'd20}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge; each bus op takes one rising edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int idx, input int n);
    ev[idx] = 1'b1;
    repeat (n) @(negedge clk);
    ev[idx] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; ev = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      bus_rd(8'(4*k), d);        chk("R1 ctl after reset", d, 32'h0);
      bus_rd(8'(32'h20 + 4*k), d); chk("R1 cnt after reset", d, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_rd(8'h40, d); chk("R2 unmapped read", d, 32'h0);

    // R3 field layout, clear bit reads back zero
    bus_wr(8'h08, 32'h2B00_0006);
    bus_rd(8'h08, d); chk("R3 ctl2 readback", d, 32'h2B00_0004);
    // R5 cycle counter ignores event code
    bus_wr(8'h00, 32'hFF00_0004);
    bus_rd(8'h00, d); chk("R5 ctl0 code forced", d, 32'h0000_0004);
    bus_wr(8'h00, 32'h0);

    // R4/R5 table of selection vectors
    for (int i = 0; i < 6; i++) begin
      logic [63:0] v;
      v = VEC[i];
      bus_wr(8'h00, 32'h0);
      bus_wr(8'h04, {v[63:56], 24'h000006});
      bus_wr(8'h08, {v[55:48], 24'h000006});
      bus_wr(8'h0C, {v[47:40], 24'h000006});
      bus_wr(8'h00, 32'h0000_0006);
      pulse(int'(v[39:32]), int'(v[31:24]));
      bus_wr(8'h00, 32'h0);
      bus_rd(8'h20, d); chk("R5 cycle count", d, {24'h0, v[31:24]});
      bus_rd(8'h24, d); chk("R4 cnt1 select", d, {24'h0, v[23:16]});
      bus_rd(8'h28, d); chk("R4 cnt2 select", d, {24'h0, v[15:8]});
      bus_rd(8'h2C, d); chk("R4 cnt3 select", d, {24'h0, v[7:0]});
    end

    // R6 global gate
    bus_wr(8'h08, 32'h0); bus_wr(8'h0C, 32'h0);
    bus_wr(8'h04, 32'h0400_0006);
    pulse(4, 10);
    bus_rd(8'h24, d); chk("R6 gated cnt1 holds", d, 32'h0);
    bus_wr(8'h00, 32'h0000_0006);
    pulse(4, 5);
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h24, d); chk("R6 cnt1 after ungate", d, 32'd5);

    // R9 zero write keeps count
    bus_wr(8'h04, 32'h0);
    bus_rd(8'h24, d); chk("R9 zero write keeps count", d, 32'd5);
    bus_rd(8'h04, d); chk("R9 zero write stops", d, 32'h0);

    // R11 writes to count words and unmapped offsets
    bus_wr(8'h24, 32'h0000_00AA);
    bus_wr(8'h50, 32'hFFFF_FFFF);
    bus_wr(8'h05, 32'h0000_0006);
    bus_rd(8'h24, d); chk("R11 count write ignored", d, 32'd5);
    bus_rd(8'h50, d); chk("R11 unmapped write", d, 32'h0);
    bus_rd(8'h04, d); chk("R11 misaligned write", d, 32'h0);

    // R8 programmable counter wraps silently
    bus_wr(8'h04, 32'h0400_0006);
    bus_wr(8'h00, 32'h0000_0006);
    pulse(4, 200);
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h00, 32'h0000_0006);
    pulse(4, 100);
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h24, d); chk("R8 cnt1 wrapped value", d, 32'd44);
    bus_rd(8'h04, d); chk("R8 cnt1 flag set", d, 32'h0400_0005);
    chk("R8 irq stays low", {31'b0, irq}, 32'h0);
    bus_wr(8'h04, 32'h0400_0006);
    bus_rd(8'h04, d); chk("R9 clear drops flag", d, 32'h0400_0004);

    // R7 cycle counter overflow freezes everything
    bus_wr(8'h00, 32'h0000_0006);
    idle(300);
    pulse(4, 5);
    bus_rd(8'h24, d); chk("R7 cnt1 frozen", d, 32'h0);
    bus_rd(8'h20, d); chk("R7 cnt0 wrapped", d, 32'h0);
    bus_rd(8'h00, d); chk("R7 ctl0 flag", d, 32'h0000_0005);
    chk("R7 irq raised", {31'b0, irq}, 32'h1);

    // R10 restart only after zero write
    bus_wr(8'h00, 32'h0000_0006);
    chk("R10 irq held after enable write", {31'b0, irq}, 32'h1);
    bus_rd(8'h00, d); chk("R10 ctl0 unchanged", d, 32'h0000_0005);
    bus_wr(8'h00, 32'h0);
    chk("R10 irq drops on zero write", {31'b0, irq}, 32'h0);
    bus_wr(8'h00, 32'h0000_0006);
    idle(20);
    bus_wr(8'h00, 32'h0000_0006);
    idle(4);
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h20, d); chk("R10 running restart ignored", d, 32'd25);

    finish_run();
  end

endmodule